// File: doc/BRIEF.md
# Set-Associative Next-State Offset Table

This block stores sparse next-state offsets for a byte-driven pattern-matching automaton and packs them densely. Each logical color (a class of automaton state with several successors) is assigned to a physical row. Several colors may share one row. A row is split into sets, and each set holds a small number of ways. Every stored item carries a validity bit, the color it belongs to, the part of the input byte not implied by its set, and a signed offset. The offset is added to the current state number by the surrounding matcher to form the next state.

A lookup presents a logical color and an input byte. The block maps the color to its row and picks the set from the low bits of the byte. It compares the color tag and input tag of every way in that set at once. It then returns the offset of the matching way together with a hit flag. A miss tells the matcher that no colored transition exists, and the matcher falls back to its other transition sources. Two write ports load the table: one assigns colors to rows, the other writes single items. Deciding how entries are packed is left to the software that builds the table.

Top module: `xlat_assoc_table`

## Requirements
- R1: Reset has four effects: rspValid, rspHit and rspOffset all read 0, every stored way becomes null (invalid), and every color maps to row 0.
- R2: A lookup sampled on clock edge k gives its result after edge k+1. rspValid is high for exactly one cycle per request, and back-to-back requests give back-to-back results. While rspValid is low, rspHit and rspOffset are 0.
- R3: The set index is the low SET_W bits of the byte (bits 6..0 with the default two ways). The input tag is the remaining high bits (bit 7 by default). A lookup hits when a valid way in that set of the color's row holds both the requested color tag and the requested input tag. A hit returns that way's offset.
- R4: A way whose color tag differs from the request does not hit, even when two colors share the same row and set.
- R5: A way whose input tag differs from the request does not hit.
- R6: A null way whose tags both match gives rspHit = 0 and rspOffset = 0.
- R7: Every miss returns rspOffset = 0.
- R8: Offsets are OFF_W-bit two's complement values (6 bits by default). Negative offsets come back unchanged.
- R9: All ways of a set are searched. When more than one valid way matches, the way with the lowest index wins.
- R10: The map port sets which row a color uses. Lookups sampled after that edge read the new row.
- R11: An item write replaces only the addressed (row, set, way) item. All other items are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| mapEn | input | 1 | Write the color-to-row map |
| mapColor | input | COLOR_W | Color whose row is set |
| mapRow | input | ROW_W | Physical row for that color |
| wrEn | input | 1 | Write one item |
| wrRow | input | ROW_W | Item row |
| wrSet | input | SET_W | Item set |
| wrWay | input | WAY_W | Item way |
| wrValid | input | 1 | 1 = live item, 0 = null |
| wrColor | input | COLOR_W | Color tag to store |
| wrTag | input | TAG_W | Input tag to store |
| wrOffset | input | OFF_W | Signed offset to store |
| lkEn | input | 1 | Lookup request |
| lkColor | input | COLOR_W | Logical color of the request |
| lkByte | input | 8 | Input byte of the request |
| rspValid | output | 1 | Result present |
| rspHit | output | 1 | A live matching way was found |
| rspOffset | output | OFF_W | Signed offset, 0 on a miss |

## Verification
Some cases never occur in a table built by a correct packing tool: two live ways carrying identical tags, and a null way whose stale tags still match a request. These are the cases that show whether the encoder priority and the null handling are right, and they cannot be reached from ordinary table contents. The stimulus reaches them by writing such items directly through the item port. In one case a higher way is written before a lower way with the same tags. In another a way is written with wrValid low but with tags equal to a later request. Shared rows are exercised by mapping two colors onto one row and placing their items in the same set, so that only the color tag separates them.

// File: rtl/xlat_assoc_pkg.sv
package xlat_assoc_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned COLORS  = 8;
  localparam int unsigned ROWS    = 4;
  localparam int unsigned WAYS    = 2;
  localparam int unsigned OFF_W   = 6;

  localparam int unsigned COLOR_W = $clog2(COLORS);
  localparam int unsigned ROW_W   = $clog2(ROWS);
  localparam int unsigned TAG_W   = $clog2(WAYS);
  localparam int unsigned WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int unsigned SET_W   = BYTE_W - TAG_W;
  localparam int unsigned SETS    = 1 << SET_W;
  localparam int unsigned ADDR_W  = ROW_W + SET_W;
  localparam int unsigned DEPTH   = 1 << ADDR_W;

  // Strobes from control to datapath
  typedef struct packed {
    logic               lookup;
    logic [ROW_W-1:0]   row;
    logic [SET_W-1:0]   set;
    logic [COLOR_W-1:0] colorTag;
    logic [TAG_W-1:0]   inTag;
    logic               write;
    logic [ROW_W-1:0]   wrRow;
    logic [SET_W-1:0]   wrSet;
    logic [WAY_W-1:0]   wrWay;
    logic               wrValid;
    logic [COLOR_W-1:0] wrColor;
    logic [TAG_W-1:0]   wrTag;
    logic [OFF_W-1:0]   wrOffset;
  } strobe_t;
endpackage

// File: rtl/xlat_assoc_ctrl.sv
module xlat_assoc_ctrl
  import xlat_assoc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               mapEn,
  input  logic [COLOR_W-1:0] mapColor,
  input  logic [ROW_W-1:0]   mapRow,
  input  logic               wrEn,
  input  logic [ROW_W-1:0]   wrRow,
  input  logic [SET_W-1:0]   wrSet,
  input  logic [WAY_W-1:0]   wrWay,
  input  logic               wrValid,
  input  logic [COLOR_W-1:0] wrColor,
  input  logic [TAG_W-1:0]   wrTag,
  input  logic [OFF_W-1:0]   wrOffset,
  input  logic               lkEn,
  input  logic [COLOR_W-1:0] lkColor,
  input  logic [BYTE_W-1:0]  lkByte,
  output strobe_t            stb
);
  logic [ROW_W-1:0]   colorRow [COLORS];
  logic               reqValid;
  logic [ROW_W-1:0]   reqRow;
  logic [SET_W-1:0]   reqSet;
  logic [COLOR_W-1:0] reqColor;
  logic [TAG_W-1:0]   reqTag;

  // Color-to-row map
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < COLORS; i++) colorRow[i] <= '0;
    end else if (mapEn) begin
      colorRow[mapColor] <= mapRow;
    end
  end

  // Request register: byte split into set index (low) and input tag (high)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqValid <= 1'b0;
      reqRow   <= '0;
      reqSet   <= '0;
      reqColor <= '0;
      reqTag   <= '0;
    end else begin
      reqValid <= lkEn;
      if (lkEn) begin
        reqRow   <= colorRow[lkColor];
        reqSet   <= lkByte[SET_W-1:0];
        reqColor <= lkColor;
        reqTag   <= lkByte[BYTE_W-1:SET_W];
      end
    end
  end

  always_comb begin
    stb.lookup   = reqValid;
    stb.row      = reqRow;
    stb.set      = reqSet;
    stb.colorTag = reqColor;
    stb.inTag    = reqTag;
    stb.write    = wrEn;
    stb.wrRow    = wrRow;
    stb.wrSet    = wrSet;
    stb.wrWay    = wrWay;
    stb.wrValid  = wrValid;
    stb.wrColor  = wrColor;
    stb.wrTag    = wrTag;
    stb.wrOffset = wrOffset;
  end
endmodule

// File: rtl/xlat_assoc_dp.sv
module xlat_assoc_dp
  import xlat_assoc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  output logic             rspValid,
  output logic             rspHit,
  output logic [OFF_W-1:0] rspOffset
);
  logic [WAYS-1:0]    validBits [DEPTH];
  logic [COLOR_W-1:0] colorMem  [DEPTH][WAYS];
  logic [TAG_W-1:0]   tagMem    [DEPTH][WAYS];
  logic [OFF_W-1:0]   offMem    [DEPTH][WAYS];

  logic [ADDR_W-1:0] wrAddr;
  logic [ADDR_W-1:0] rdAddr;
  logic [WAYS-1:0]   live;
  logic [WAY_W-1:0]  selWay;
  logic              anyHit;
  logic [OFF_W-1:0]  selOff;

  assign wrAddr = {stb.wrRow, stb.wrSet};
  assign rdAddr = {stb.row, stb.set};

  // Validity bits are reset; payload fields are not
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int a = 0; a < DEPTH; a++) validBits[a] <= '0;
    end else if (stb.write) begin
      validBits[wrAddr][stb.wrWay] <= stb.wrValid;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.write) begin
      colorMem[wrAddr][stb.wrWay] <= stb.wrColor;
      tagMem[wrAddr][stb.wrWay]   <= stb.wrTag;
      offMem[wrAddr][stb.wrWay]   <= stb.wrOffset;
    end
  end

  // Parallel tag compare, one comparator pair per way
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic colorEq;
    logic tagEq;
    assign colorEq = (colorMem[rdAddr][w] == stb.colorTag);
    assign tagEq   = (tagMem[rdAddr][w] == stb.inTag);
    assign live[w] = validBits[rdAddr][w] & colorEq & tagEq;
  end

  // Priority encoder: lowest live way wins
  always_comb begin
    selWay = '0;
    anyHit = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (live[w]) begin
        selWay = WAY_W'(w);
        anyHit = 1'b1;
      end
    end
  end

  assign selOff = offMem[rdAddr][selWay];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid  <= 1'b0;
      rspHit    <= 1'b0;
      rspOffset <= '0;
    end else begin
      rspValid  <= stb.lookup;
      rspHit    <= stb.lookup & anyHit;
      rspOffset <= (stb.lookup && anyHit) ? selOff : '0;
    end
  end
endmodule

// File: rtl/xlat_assoc_table.sv
module xlat_assoc_table
  import xlat_assoc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               mapEn,
  input  logic [COLOR_W-1:0] mapColor,
  input  logic [ROW_W-1:0]   mapRow,
  input  logic               wrEn,
  input  logic [ROW_W-1:0]   wrRow,
  input  logic [SET_W-1:0]   wrSet,
  input  logic [WAY_W-1:0]   wrWay,
  input  logic               wrValid,
  input  logic [COLOR_W-1:0] wrColor,
  input  logic [TAG_W-1:0]   wrTag,
  input  logic [OFF_W-1:0]   wrOffset,
  input  logic               lkEn,
  input  logic [COLOR_W-1:0] lkColor,
  input  logic [BYTE_W-1:0]  lkByte,
  output logic               rspValid,
  output logic               rspHit,
  output logic [OFF_W-1:0]   rspOffset
);
  strobe_t stb;

  xlat_assoc_ctrl i_ctrl (
    .clk(clk), .rstN(rstN),
    .mapEn(mapEn), .mapColor(mapColor), .mapRow(mapRow),
    .wrEn(wrEn), .wrRow(wrRow), .wrSet(wrSet), .wrWay(wrWay),
    .wrValid(wrValid), .wrColor(wrColor), .wrTag(wrTag), .wrOffset(wrOffset),
    .lkEn(lkEn), .lkColor(lkColor), .lkByte(lkByte),
    .stb(stb)
  );

  xlat_assoc_dp i_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .rspValid(rspValid), .rspHit(rspHit), .rspOffset(rspOffset)
  );
endmodule

// File: rtl/xlat_assoc_chk.sv
module xlat_assoc_chk
  import xlat_assoc_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             lkEn,
  input logic             rspValid,
  input logic             rspHit,
  input logic [OFF_W-1:0] rspOffset
);
  logic [1:0] sinceReset;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceReset <= '0;
    else if (sinceReset != 2'd2) sinceReset <= sinceReset + 2'd1;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (sinceReset == 2'd0) |-> !rspValid); // R1

  AST_TWO_EDGE_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (sinceReset == 2'd2) |-> (rspValid == $past(lkEn, 2))); // R2

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> (!rspHit && rspOffset == '0)); // R2

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspHit) |-> (rspOffset == '0)); // R7
endmodule

bind xlat_assoc_table xlat_assoc_chk i_chk (
  .clk(clk), .rstN(rstN), .lkEn(lkEn),
  .rspValid(rspValid), .rspHit(rspHit), .rspOffset(rspOffset)
);

// File: tb/test_xlat_assoc_table.sv
module test_xlat_assoc_table;
  import xlat_assoc_pkg::*;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               mapEn = 1'b0;
  logic [COLOR_W-1:0] mapColor = '0;
  logic [ROW_W-1:0]   mapRow = '0;
  logic               wrEn = 1'b0;
  logic [ROW_W-1:0]   wrRow = '0;
  logic [SET_W-1:0]   wrSet = '0;
  logic [WAY_W-1:0]   wrWay = '0;
  logic               wrValid = 1'b0;
  logic [COLOR_W-1:0] wrColor = '0;
  logic [TAG_W-1:0]   wrTag = '0;
  logic [OFF_W-1:0]   wrOffset = '0;
  logic               lkEn = 1'b0;
  logic [COLOR_W-1:0] lkColor = '0;
  logic [BYTE_W-1:0]  lkByte = '0;
  logic               rspValid;
  logic               rspHit;
  logic [OFF_W-1:0]   rspOffset;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  xlat_assoc_table i_xlat_assoc_table (.*);

  // Vector: {color[2:0], byte[7:0], expHit, expOffset[5:0]}
  localparam int NV = 13;
  localparam logic [17:0] VEC [NV] = '{
    {3'd1, 8'h61, 1'b1, 6'h03},  // R3 basic hit
    {3'd2, 8'h61, 1'b1, 6'h3D},  // R4 other color same set, -3
    {3'd5, 8'h61, 1'b0, 6'h00},  // R4 unmatched color in row 0
    {3'd1, 8'hE1, 1'b0, 6'h00},  // R5 input tag differs
    {3'd1, 8'hE3, 1'b1, 6'h05},  // R9 way 0 of set 0x63
    {3'd1, 8'h63, 1'b1, 6'h01},  // R9 way 1 of set 0x63
    {3'd2, 8'h63, 1'b0, 6'h00},  // R4 color tag differs in both ways
    {3'd3, 8'h6F, 1'b1, 6'h39},  // R8 negative offset -7
    {3'd3, 8'hEF, 1'b0, 6'h00},  // R6 null way with matching tags
    {3'd4, 8'h10, 1'b1, 6'h02},  // R9 duplicate live match, lowest way
    {3'd4, 8'h90, 1'b0, 6'h00},  // R5 input tag differs
    {3'd1, 8'h00, 1'b0, 6'h00},  // R7 empty set
    {3'd3, 8'h61, 1'b0, 6'h00}   // R10 row 1 has nothing at set 0x61
  };
  localparam string VEC_REQ [NV] = '{"R3", "R4", "R4", "R5", "R9", "R9", "R4",
                                      "R8", "R6", "R9", "R5", "R7", "R10"};

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic mapColorRow(input int c, input int r);
    @(negedge clk);
    mapEn = 1'b1; mapColor = COLOR_W'(c); mapRow = ROW_W'(r);
    @(negedge clk);
    mapEn = 1'b0;
  endtask

  task automatic writeItem(input int r, input int s, input int w, input bit v,
                           input int c, input int t, input int off);
    @(negedge clk);
    wrEn = 1'b1; wrRow = ROW_W'(r); wrSet = SET_W'(s); wrWay = WAY_W'(w);
    wrValid = v; wrColor = COLOR_W'(c); wrTag = TAG_W'(t); wrOffset = OFF_W'(off);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // Issues one lookup and returns the response one edge after capture
  task automatic lookup(input int c, input int b, output bit earlyValid,
                        output bit v, output bit h, output int off);
    @(negedge clk);
    lkEn = 1'b1; lkColor = COLOR_W'(c); lkByte = BYTE_W'(b);
    @(negedge clk);
    lkEn = 1'b0;
    earlyValid = rspValid;
    @(negedge clk);
    v = rspValid; h = rspHit; off = int'($signed(rspOffset));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit ev, v, h;
    int off;

    // R1: outputs held at zero during reset
    repeat (3) @(negedge clk);
    chk("R1", "rspValid in reset", rspValid, 0);
    chk("R1", "rspHit in reset", rspHit, 0);
    chk("R1", "rspOffset in reset", int'(rspOffset), 0);
    rstN = 1'b1;

    // R1: every way null after reset
    lookup(0, 8'h00, ev, v, h, off);
    chk("R1", "hit on fresh table", h, 0);

    // Load: colors 1,2 share row 0; colors 3,4 share row 1
    mapColorRow(1, 0);
    mapColorRow(2, 0);
    mapColorRow(3, 1);
    mapColorRow(4, 1);
    writeItem(0, 8'h61, 0, 1'b1, 1, 0, 3);
    writeItem(0, 8'h61, 1, 1'b1, 2, 0, -3);
    writeItem(0, 8'h63, 0, 1'b1, 1, 1, 5);
    writeItem(0, 8'h63, 1, 1'b1, 1, 0, 1);
    writeItem(1, 8'h6F, 0, 1'b1, 3, 0, -7);
    writeItem(1, 8'h6F, 1, 1'b0, 3, 1, 9);
    writeItem(1, 8'h10, 1, 1'b1, 4, 0, 31);
    writeItem(1, 8'h10, 0, 1'b1, 4, 0, 2);

    for (int i = 0; i < NV; i++) begin
      lookup(int'(VEC[i][17:15]), int'(VEC[i][14:7]), ev, v, h, off);
      chk(VEC_REQ[i], $sformatf("vec %0d early valid", i), ev, 0);
      chk(VEC_REQ[i], $sformatf("vec %0d valid", i), v, 1);
      chk(VEC_REQ[i], $sformatf("vec %0d hit", i), h, int'(VEC[i][6]));
      chk(VEC_REQ[i], $sformatf("vec %0d offset", i), off, int'($signed(VEC[i][5:0])));
    end

    // R2: back-to-back lookups give back-to-back results, then idle
    @(negedge clk);
    lkEn = 1'b1; lkColor = 3'd1; lkByte = 8'h61;
    @(negedge clk);
    lkColor = 3'd3; lkByte = 8'h6F;
    @(negedge clk);
    lkEn = 1'b0;
    chk("R2", "pipelined first offset", int'($signed(rspOffset)), 3);
    @(negedge clk);
    chk("R2", "pipelined second valid", rspValid, 1);
    chk("R2", "pipelined second offset", int'($signed(rspOffset)), -7);
    @(negedge clk);
    chk("R2", "valid drops when idle", rspValid, 0);
    chk("R2", "offset zero when idle", int'(rspOffset), 0);

    // R10: remap color 1 to row 1, then back
    mapColorRow(1, 1);
    lookup(1, 8'h61, ev, v, h, off);
    chk("R10", "hit after remap", h, 0);
    mapColorRow(1, 0);
    lookup(1, 8'h61, ev, v, h, off);
    chk("R10", "offset after restoring map", off, 3);

    // R11: overwrite one way, neighbour unchanged
    writeItem(0, 8'h61, 0, 1'b1, 1, 0, -1);
    lookup(1, 8'h61, ev, v, h, off);
    chk("R11", "overwritten offset", off, -1);
    lookup(2, 8'h61, ev, v, h, off);
    chk("R11", "neighbour way offset", off, -3);

    // R1: reset in mid-run clears ways and map
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk("R1", "rspValid after mid-run reset", rspValid, 0);
    rstN = 1'b1;
    lookup(2, 8'h61, ev, v, h, off);
    chk("R1", "hit after mid-run reset", h, 0);
    chk("R7", "offset after mid-run reset", off, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule